// File: doc/BRIEF.md
# Debug Exception and Status Controller

This block sits beside the instruction pipeline. It gathers the per-slot breakpoint address matches, the instruction-retire strobe and any attempt to touch the protected debug registers. It then decides whether a debug exception is due and, if so, whether it is a fault or a trap. A fault is reported before the instruction takes effect. A trap is reported after it.

The block holds a status word with one sticky hit bit per breakpoint slot, an access-detected bit and a single-step bit. It also holds three control flags. The step flag raises an exception after every retired instruction. The resume flag masks execute breakpoints until one instruction retires. The access-guard flag turns any debug-register access into a fault.

Software sets the step and access-guard flags through a small write port. The resume flag can only be loaded by the interrupt-return event. Software clears the status word through a synchronous write.

Top module: `dbg_exc_ctrl`

## Requirements
- R1: A hit on an enabled slot whose kind is execute (kind code 2'b00) while the resume flag is 0 gives `exc_req`=1 with `exc_is_fault`=1 and sets that slot's status bit.
- R2: A hit on an enabled slot of any other kind (2'b01 write, 2'b10 I/O, 2'b11 read/write) gives `exc_req`=1 with `exc_is_fault`=0. This holds whatever the resume flag is.
- R3: A hit on a disabled slot sets that slot's status bit (bit i for slot i) but raises no exception.
- R4: With the access-guard flag at 1, a debug-register access gives a fault, sets status bit NUM_SLOTS, and clears the access-guard flag. With the flag at 0, an access has no effect.
- R5: With the step flag at 1, a retire strobe gives a trap, sets status bit NUM_SLOTS+1, and clears the step flag.
- R6: A software-interrupt strobe clears the step flag without raising an exception.
- R7: While the resume flag is 1, execute-kind hits set no status bit and raise no exception. A retire strobe clears the resume flag.
- R8: The resume flag takes the value of `iret_rf` on an interrupt-return strobe, and on no other write. `flags_wdata` carries only the step flag (bit 1) and the access-guard flag (bit 0).
- R9: Status bits stay set until `stat_wr` loads `stat_wdata`. Hardware set events in the same cycle win over the written value. Hardware flag updates win over a same-cycle `flags_wr`.
- R10: Causes in the same cycle set all their status bits and give a single request. That request is a fault if any of the causes is a fault.
- R11: `exc_req`, `exc_is_fault`, the status word and the flags update at the clock edge that samples the cause. `exc_req` is 0 in any cycle after an edge that saw no cause.
- R12: After reset, the status word, all flags and `exc_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_hit | input | NUM_SLOTS | Per-slot address match this cycle |
| slot_en | input | NUM_SLOTS | Per-slot enable |
| slot_kind | input | 2*NUM_SLOTS | Per-slot access kind, 2 bits per slot |
| retire | input | 1 | An instruction retired this cycle |
| dreg_access | input | 1 | Attempted debug-register access |
| swint | input | 1 | Software-interrupt instruction executed |
| iret | input | 1 | Interrupt-return event |
| iret_rf | input | 1 | Saved resume flag restored by `iret` |
| flags_wr | input | 1 | Write strobe for the step and access-guard flags |
| flags_wdata | input | 2 | {step, access-guard} write value |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | NUM_SLOTS+2 | Status word write value |
| exc_req | output | 1 | Debug exception request |
| exc_is_fault | output | 1 | 1 means fault, 0 means trap |
| status | output | NUM_SLOTS+2 | {single-step, access-detected, slot hits} |
| tf | output | 1 | Step flag |
| rf | output | 1 | Resume flag |
| gd | output | 1 | Access-guard flag |

## Verification
Every output of this block is registered once. A cause driven during one cycle therefore appears on `exc_req`, `exc_is_fault`, `status` and the flags right after the next rising edge. The bench changes inputs on the falling edge and steps one full cycle. It reads the outputs at the following falling edge and then removes the stimulus. A second idle cycle then confirms that the request has dropped while the status bits have stayed set.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;
  typedef enum logic [1:0] {
    KIND_EXEC  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_IO    = 2'b10,
    KIND_RDWR  = 2'b11
  } slot_kind_e;
endpackage

// File: rtl/dbg_cause_decode.sv
module dbg_cause_decode #(
  parameter int NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]   slot_hit,
  input  logic [NUM_SLOTS-1:0]   slot_en,
  input  logic [2*NUM_SLOTS-1:0] slot_kind,
  input  logic                   rf,
  output logic [NUM_SLOTS-1:0]   hit_mark,
  output logic                   exec_trig,
  output logic                   data_trig
);
  import dbg_exc_pkg::*;

  logic [NUM_SLOTS-1:0] fire_exec;
  logic [NUM_SLOTS-1:0] fire_data;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic is_exec;
    logic seen;
    // Execute hits are masked while the resume flag is set.
    assign is_exec      = (slot_kind[2*i +: 2] == KIND_EXEC);
    assign seen         = slot_hit[i] & ~(is_exec & rf);
    assign hit_mark[i]  = seen;
    assign fire_exec[i] = seen & slot_en[i] & is_exec;
    assign fire_data[i] = seen & slot_en[i] & ~is_exec;
  end

  assign exec_trig = |fire_exec;
  assign data_trig = |fire_data;
endmodule

// File: rtl/dbg_flag_regs.sv
module dbg_flag_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flags_wr,
  input  logic [1:0] flags_wdata,
  input  logic       gd_take,
  input  logic       exc_take,
  input  logic       swint,
  input  logic       retire,
  input  logic       iret,
  input  logic       iret_rf,
  output logic       tf,
  output logic       rf,
  output logic       gd
);
  logic tf_d, rf_d, gd_d;

  always_comb begin
    tf_d = tf;
    gd_d = gd;
    rf_d = rf;
    if (flags_wr) begin
      tf_d = flags_wdata[1];
      gd_d = flags_wdata[0];
    end
    // Hardware updates override the software write.
    if (exc_take || swint) tf_d = 1'b0;
    if (gd_take)           gd_d = 1'b0;
    if (iret)              rf_d = iret_rf;
    else if (retire)       rf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf <= 1'b0;
      rf <= 1'b0;
      gd <= 1'b0;
    end else begin
      tf <= tf_d;
      rf <= rf_d;
      gd <= gd_d;
    end
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_wdata,
  input  logic [SW-1:0] set_bits,
  output logic [SW-1:0] status
);
  logic [SW-1:0] status_d;
  logic          status_en;

  assign status_en = stat_wr | (|set_bits);

  always_comb begin
    status_d = stat_wr ? stat_wdata : status;
    status_d = status_d | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (status_en) begin
      status <= status_d;
    end
  end
endmodule

// File: rtl/dbg_exc_ctrl.sv
module dbg_exc_ctrl #(
  parameter int NUM_SLOTS = 4,
  localparam int SW = NUM_SLOTS + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS-1:0]   slot_hit,
  input  logic [NUM_SLOTS-1:0]   slot_en,
  input  logic [2*NUM_SLOTS-1:0] slot_kind,
  input  logic                   retire,
  input  logic                   dreg_access,
  input  logic                   swint,
  input  logic                   iret,
  input  logic                   iret_rf,
  input  logic                   flags_wr,
  input  logic [1:0]             flags_wdata,
  input  logic                   stat_wr,
  input  logic [SW-1:0]          stat_wdata,
  output logic                   exc_req,
  output logic                   exc_is_fault,
  output logic [SW-1:0]          status,
  output logic                   tf,
  output logic                   rf,
  output logic                   gd
);
  logic [NUM_SLOTS-1:0] hit_mark;
  logic                 exec_trig, data_trig;
  logic                 gd_evt, ss_evt, any_cause, fault_cause;
  logic [SW-1:0]        set_bits;
  logic                 req_d, fault_d;

  dbg_cause_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .slot_hit  (slot_hit),
    .slot_en   (slot_en),
    .slot_kind (slot_kind),
    .rf        (rf),
    .hit_mark  (hit_mark),
    .exec_trig (exec_trig),
    .data_trig (data_trig)
  );

  assign gd_evt      = dreg_access & gd;
  assign ss_evt      = retire & tf;
  assign any_cause   = exec_trig | data_trig | gd_evt | ss_evt;
  assign fault_cause = exec_trig | gd_evt;
  assign set_bits    = {ss_evt, gd_evt, hit_mark};

  dbg_flag_regs u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_wr    (flags_wr),
    .flags_wdata (flags_wdata),
    .gd_take     (gd_evt),
    .exc_take    (any_cause),
    .swint       (swint),
    .retire      (retire),
    .iret        (iret),
    .iret_rf     (iret_rf),
    .tf          (tf),
    .rf          (rf),
    .gd          (gd)
  );

  dbg_status_reg #(.SW(SW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .set_bits   (set_bits),
    .status     (status)
  );

  always_comb begin
    req_d   = any_cause;
    fault_d = any_cause & fault_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req      <= 1'b0;
      exc_is_fault <= 1'b0;
    end else begin
      exc_req      <= req_d;
      exc_is_fault <= fault_d;
    end
  end
endmodule

// File: rtl/dbg_exc_ctrl_chk.sv
module dbg_exc_ctrl_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int SW = NUM_SLOTS + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire,
  input logic          dreg_access,
  input logic          swint,
  input logic          iret,
  input logic          iret_rf,
  input logic          stat_wr,
  input logic          exc_req,
  input logic          exc_is_fault,
  input logic [SW-1:0] status,
  input logic          tf,
  input logic          rf,
  input logic          gd
);
  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    exc_is_fault |-> exc_req); // R1

  AST_GUARD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (gd && dreg_access) |=> (exc_req && exc_is_fault && status[NUM_SLOTS] && !gd)); // R4

  AST_STEP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tf && retire) |=> (exc_req && status[NUM_SLOTS+1] && !tf)); // R5

  AST_SWINT_CLEARS_TF: assert property (@(posedge clk) disable iff (!rst_n)
    swint |=> !tf); // R6

  AST_RF_ONE_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    (rf && retire && !iret) |=> !rf); // R7

  AST_IRET_LOADS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    iret |=> (rf == $past(iret_rf))); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status))); // R9

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (status != '0)); // R11
endmodule

bind dbg_exc_ctrl dbg_exc_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire       (retire),
  .dreg_access  (dreg_access),
  .swint        (swint),
  .iret         (iret),
  .iret_rf      (iret_rf),
  .stat_wr      (stat_wr),
  .exc_req      (exc_req),
  .exc_is_fault (exc_is_fault),
  .status       (status),
  .tf           (tf),
  .rf           (rf),
  .gd           (gd)
);

// File: tb/dbg_exc_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_exc_ctrl_bench;
  localparam int N  = 4;
  localparam int SW = N + 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  slot_hit, slot_en;
  logic [2*N-1:0] slot_kind;
  logic          retire, dreg_access, swint, iret, iret_rf;
  logic          flags_wr;
  logic [1:0]    flags_wdata;
  logic          stat_wr;
  logic [SW-1:0] stat_wdata;
  logic          exc_req, exc_is_fault, tf, rf, gd;
  logic [SW-1:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dbg_exc_ctrl #(.NUM_SLOTS(N)) u_dbg_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .slot_en(slot_en),
    .slot_kind(slot_kind), .retire(retire), .dreg_access(dreg_access),
    .swint(swint), .iret(iret), .iret_rf(iret_rf), .flags_wr(flags_wr),
    .flags_wdata(flags_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .exc_req(exc_req), .exc_is_fault(exc_is_fault), .status(status),
    .tf(tf), .rf(rf), .gd(gd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    slot_hit = '0; retire = 0; dreg_access = 0; swint = 0; iret = 0;
    iret_rf = 0; flags_wr = 0; flags_wdata = '0; stat_wr = 0; stat_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_status();
    idle(); stat_wr = 1; stat_wdata = '0; step(); idle();
  endtask

  // slot0 exec, slot1 rd/wr, slot2 write, slot3 I/O
  task automatic t_reset();
    check("R12 status", status, 0);
    check("R12 exc_req", exc_req, 0);
    check("R12 flags", {tf, rf, gd}, 0);
  endtask

  task automatic t_exec_fault();
    idle(); slot_en = 4'b1101; slot_hit = 4'b0001; step();
    check("R1 exc_req", exc_req, 1);
    check("R1 fault", exc_is_fault, 1);
    check("R1 status", status, 6'h01);
    idle(); step();
    check("R11 req drops", exc_req, 0);
    check("R9 sticky", status, 6'h01);
    clear_status();
    check("R9 cleared", status, 0);
  endtask

  task automatic t_data_trap();
    idle(); slot_hit = 4'b0100; step();
    check("R2 write req", exc_req, 1);
    check("R2 write trap", exc_is_fault, 0);
    idle(); slot_hit = 4'b1000; step();
    check("R2 io trap", {exc_req, exc_is_fault}, 2'b10);
    check("R2 status", status, 6'h0C);
    clear_status();
  endtask

  task automatic t_disabled();
    idle(); slot_hit = 4'b0010; step();
    check("R3 no req", exc_req, 0);
    check("R3 status", status, 6'h02);
    clear_status();
  endtask

  task automatic t_guard();
    idle(); dreg_access = 1; step();
    check("R4 guard off no req", exc_req, 0);
    check("R4 guard off status", status, 0);
    idle(); flags_wr = 1; flags_wdata = 2'b01; step();
    check("R4 gd set", gd, 1);
    idle(); dreg_access = 1; step();
    check("R4 fault", {exc_req, exc_is_fault}, 2'b11);
    check("R4 status", status, 6'h10);
    check("R4 gd cleared", gd, 0);
    idle(); dreg_access = 1; step();
    check("R4 second access", exc_req, 0);
    clear_status();
  endtask

  task automatic t_step();
    idle(); flags_wr = 1; flags_wdata = 2'b10; step();
    check("R5 tf set", tf, 1);
    idle(); retire = 1; step();
    check("R5 trap", {exc_req, exc_is_fault}, 2'b10);
    check("R5 status", status, 6'h20);
    check("R5 tf cleared", tf, 0);
    idle(); retire = 1; step();
    check("R5 no more", exc_req, 0);
    clear_status();
  endtask

  task automatic t_swint();
    idle(); flags_wr = 1; flags_wdata = 2'b10; step();
    idle(); swint = 1; step();
    check("R6 tf cleared", tf, 0);
    check("R6 no req", exc_req, 0);
  endtask

  task automatic t_resume();
    idle(); iret = 1; iret_rf = 1; step();
    check("R8 iret loads", rf, 1);
    idle(); flags_wr = 1; flags_wdata = 2'b00; step();
    check("R8 write keeps rf", rf, 1);
    idle(); slot_hit = 4'b0001; step();
    check("R7 masked req", exc_req, 0);
    check("R7 masked status", status, 0);
    idle(); slot_hit = 4'b0100; step();
    check("R2 data under rf", {exc_req, exc_is_fault}, 2'b10);
    idle(); retire = 1; step();
    check("R7 rf cleared", rf, 0);
    idle(); slot_hit = 4'b0001; step();
    check("R7 exec after", {exc_req, exc_is_fault}, 2'b11);
    idle(); iret = 1; iret_rf = 1; step();
    idle(); iret = 1; iret_rf = 0; step();
    check("R8 iret zero", rf, 0);
    clear_status();
  endtask

  task automatic t_coincide();
    idle(); flags_wr = 1; flags_wdata = 2'b11; step();
    idle(); slot_hit = 4'b0100; retire = 1; dreg_access = 1; step();
    check("R10 fault", {exc_req, exc_is_fault}, 2'b11);
    check("R10 status", status, 6'h34);
    check("R10 flags", {tf, gd}, 0);
    clear_status();
  endtask

  task automatic t_write_race();
    idle(); stat_wr = 1; stat_wdata = '0; slot_hit = 4'b0010; step();
    check("R9 event wins", status, 6'h02);
    idle(); stat_wr = 1; stat_wdata = 6'h3F; step();
    check("R9 write loads", status, 6'h3F);
    clear_status();
  endtask

  initial begin
    slot_en = '0; slot_kind = 8'b10_01_11_00;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exec_fault();
    t_data_trap();
    t_disabled();
    t_guard();
    t_step();
    t_swint();
    t_resume();
    t_coincide();
    t_write_race();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule